// File: doc/BRIEF.md
# Repetition Rate Matcher

This block lengthens a serial bit stream to a target size by emitting some input bits more than once. An error accumulator decides how many copies each bit gets. The accumulator starts from an initial offset. It is lowered by a fixed step when a bit is taken and raised by a second step for each extra copy. A bit is finished once the accumulator is above zero. The spacing of the repeated bits across the block is therefore even and fully set by three numbers.

The block has a valid/ready input stream and a valid/ready output stream. Before each block, software or an upstream sequencer presents the initial offset, the two step sizes and the input length, and then pulses a start strobe. The block accepts exactly that many input bits. It flags the last output copy and then returns to idle until the next start. While copies of the current bit are still owed, the input side is stalled.

Top module: `rep_rate_matcher`

## Requirements
- R1: After reset, in_ready, out_valid and out_last are low, and they stay low until a start strobe arrives.
- R2: A start strobe in idle latches cfg_eini (two's complement) as the error value, cfg_eminus and cfg_eplus (unsigned, cfg_eplus nonzero) as the step sizes, and cfg_len as the bit count. A start with cfg_len equal to zero leaves the block idle, and it neither accepts input nor produces output.
- R3: Every accepted input bit is emitted at least once, and that first copy comes before any copy of a later bit. The step cfg_eminus is subtracted from the error when the bit is accepted.
- R4: After each copy, if the error is zero or negative, the same bit is emitted again and cfg_eplus is added. The bit is complete when the error is positive. The total output count equals the bit count plus the number of additions.
- R5: in_ready is low whenever further copies of the current bit are still owed, and a new bit is only accepted once all copies of the previous bit have been handed over.
- R6: out_last is high only on the final copy of the last input bit. After that copy is taken, the block is idle, with in_ready and out_valid low, and it accepts no more than cfg_len bits per block.
- R7: While out_valid is high and out_ready is low, out_valid, out_bit and out_last hold their values.
- R8: A start strobe that arrives while a block is in progress is ignored, and the block in flight completes with its original settings.
- R9: The number of copies does not depend on the value of the bit. Bits that carry data and bits that carry parity are treated alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start strobe, one cycle |
| cfg_eini | input | ERR_W | Initial error, two's complement |
| cfg_eminus | input | ERR_W | Step subtracted per accepted bit |
| cfg_eplus | input | ERR_W | Step added per repeat copy, nonzero |
| cfg_len | input | LEN_W | Number of input bits in the block |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted when high with in_valid |
| in_bit | input | 1 | Input data bit |
| out_valid | output | 1 | Output copy valid |
| out_ready | input | 1 | Downstream ready |
| out_bit | output | 1 | Output data bit |
| out_last | output | 1 | Final copy of the block |

## Verification
The hardest case to reach is a new input bit being taken in the very cycle that the last copy of the previous bit leaves. The stimulus gets there with settings that give exactly one copy per bit, and others that give one to four copies per bit, with input gaps and output stalls drawn from a pseudo-random sequence. At each input handshake, the bench compares the number of outputs already taken with a software model of the recurrence. A restart strobe injected mid-block, with different settings, and a zero-length block cover the start rules.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } rrm_state_e;

    typedef enum logic [1:0] {
        ERR_HOLD = 2'd0,
        ERR_LOAD = 2'd1,
        ERR_SUB  = 2'd2,
        ERR_ADD  = 2'd3
    } rrm_err_op_e;

endpackage

// File: rtl/rrm_err_unit.sv
`timescale 1ns/1ps
module rrm_err_unit
    import rrm_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rrm_err_op_e      op,
    input  logic [ERR_W-1:0] init_val,
    input  logic [ERR_W-1:0] step_down,
    input  logic [ERR_W-1:0] step_up,
    output logic             err_pos
);
    // two guard bits: init minus a full-range step never wraps
    localparam int ACC_W = ERR_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ERR_W-1:0] down;
        logic [ERR_W-1:0] up;
    } err_regs_t;

    err_regs_t r_d, r_q;
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] init_ext;
    logic signed [ACC_W-1:0] down_ext;
    logic signed [ACC_W-1:0] up_ext;

    always_comb begin
        acc_s    = $signed(r_q.acc);
        init_ext = $signed({{2{init_val[ERR_W-1]}}, init_val});
        down_ext = $signed({2'b00, r_q.down});
        up_ext   = $signed({2'b00, r_q.up});
        r_d      = r_q;
        unique case (op)
            ERR_LOAD: begin
                r_d.acc  = init_ext;
                r_d.down = step_down;
                r_d.up   = step_up;
            end
            ERR_SUB:  r_d.acc = acc_s - down_ext;
            ERR_ADD:  r_d.acc = acc_s + up_ext;
            default:  r_d     = r_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign err_pos = (acc_s > 0);

    // R4
    add_when_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ERR_ADD) |-> (acc_s <= 0));

    // R4
    add_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ERR_ADD && r_q.up != '0) |=> ($signed(r_q.acc) > $past(acc_s)));

endmodule

// File: rtl/rrm_bit_count.sv
`timescale 1ns/1ps
module rrm_bit_count #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    input  logic [LEN_W-1:0] len_in,
    output logic             at_end
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.cnt = '0;
            c_d.len = len_in;
        end else if (inc) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign at_end = (c_q.cnt == c_q.len);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= c_q.len);

    // R6
    no_take_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_end);

endmodule

// File: rtl/rrm_ctrl.sv
`timescale 1ns/1ps
module rrm_ctrl
    import rrm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        len_zero,
    input  logic        in_valid,
    input  logic        in_bit,
    input  logic        out_ready,
    input  logic        err_pos,
    input  logic        cnt_end,
    output logic        in_ready,
    output logic        out_valid,
    output logic        out_bit,
    output logic        out_last,
    output rrm_err_op_e err_op,
    output logic        cnt_load,
    output logic        cnt_inc
);
    typedef struct packed {
        rrm_state_e state;
        logic       held;
    } ctl_regs_t;

    ctl_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        err_op    = ERR_HOLD;
        cnt_load  = 1'b0;
        cnt_inc   = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start && !len_zero) begin
                    s_d.state = ST_FETCH;
                    err_op    = ERR_LOAD;
                    cnt_load  = 1'b1;
                end
            end
            ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    s_d.held  = in_bit;
                    s_d.state = ST_EMIT;
                    err_op    = ERR_SUB;
                    cnt_inc   = 1'b1;
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                out_last  = err_pos && cnt_end;
                // next bit may enter in the same cycle its predecessor leaves
                in_ready  = err_pos && !cnt_end && out_ready;
                if (out_ready) begin
                    if (!err_pos) begin
                        err_op = ERR_ADD;
                    end else if (cnt_end) begin
                        s_d.state = ST_IDLE;
                    end else if (in_valid) begin
                        s_d.held = in_bit;
                        err_op   = ERR_SUB;
                        cnt_inc  = 1'b1;
                    end else begin
                        s_d.state = ST_FETCH;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        out_bit = s_q.held;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, held: 1'b0};
        else        s_q <= s_d;
    end

    // R3
    first_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_bit == $past(in_bit)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bit) && $stable(out_last)));

    // R6
    last_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));

    // R5
    owed_copy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !err_pos) |-> !in_ready);

endmodule

// File: rtl/rep_rate_matcher.sv
`timescale 1ns/1ps
module rep_rate_matcher
    import rrm_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic [ERR_W-1:0] cfg_eini,
    input  logic [ERR_W-1:0] cfg_eminus,
    input  logic [ERR_W-1:0] cfg_eplus,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_bit,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_last
);
    rrm_err_op_e err_op;
    logic        err_pos;
    logic        cnt_load;
    logic        cnt_inc;
    logic        cnt_end;
    logic        len_zero;

    assign len_zero = (cfg_len == '0);

    rrm_err_unit #(.ERR_W(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (err_op),
        .init_val (cfg_eini),
        .step_down(cfg_eminus),
        .step_up  (cfg_eplus),
        .err_pos  (err_pos)
    );

    rrm_bit_count #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .inc   (cnt_inc),
        .len_in(cfg_len),
        .at_end(cnt_end)
    );

    rrm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cfg_start),
        .len_zero (len_zero),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .out_ready(out_ready),
        .err_pos  (err_pos),
        .cnt_end  (cnt_end),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_bit  (out_bit),
        .out_last (out_last),
        .err_op   (err_op),
        .cnt_load (cnt_load),
        .cnt_inc  (cnt_inc)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && !in_ready && !out_last));

endmodule

// File: tb/test_rep_rate_matcher.sv
`timescale 1ns/1ps
module test_rep_rate_matcher;
    localparam int ERR_W = 16;
    localparam int LEN_W = 16;
    localparam int NV    = 8;
    localparam int MAXO  = 1024;

    // eini, eminus, eplus, len, seed, mode (b0 input gaps, b1 output stalls, b2 restart try)
    localparam int VEC [NV][6] = '{
        '{1,  1, 1,  8, 5,  0},
        '{3,  2, 6, 20, 11, 1},
        '{10, 0, 4, 12, 23, 2},
        '{1,  5, 2,  6, 37, 3},
        '{0,  1, 3, 30, 41, 3},
        '{2,  7, 2,  1, 53, 2},
        '{5,  3, 7, 40, 61, 7},
        '{7,  4, 9, 64, 71, 3}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_start;
    logic [ERR_W-1:0] cfg_eini, cfg_eminus, cfg_eplus;
    logic [LEN_W-1:0] cfg_len;
    logic in_valid, in_ready, in_bit;
    logic out_valid, out_ready, out_bit, out_last;

    always #4 clk = ~clk;

    rep_rate_matcher #(.ERR_W(ERR_W), .LEN_W(LEN_W)) i_rep_rate_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .cfg_eini(cfg_eini), .cfg_eminus(cfg_eminus), .cfg_eplus(cfg_eplus),
        .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
        .out_bit(out_bit), .out_last(out_last)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int unsigned rs = 32'h1234_5678;
    bit src [MAXO];
    bit exp_bits [MAXO];
    int exp_first [MAXO];
    int exp_len;

    function automatic int unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // software model of the repeat recurrence
    task automatic build_model(input int eini, input int em, input int ep,
                               input int n, input int seed);
        int e;
        int k;
        rs = 32'h9E37_79B9 ^ (seed * 977 + 1);
        for (int m = 0; m < n; m++) src[m] = rnd() & 1;
        e = eini;
        k = 0;
        for (int m = 0; m < n; m++) begin
            e = e - em;
            exp_first[m] = k;
            exp_bits[k] = src[m];
            k++;
            while (e <= 0) begin
                exp_bits[k] = src[m];
                k++;
                e = e + ep;
            end
        end
        exp_len = k;
    endtask

    task automatic run_vec(input int v);
        int n, mode, idx, oc, mism, last_bad, stall_bad, hold_bad;
        bit got_last, took, restarted, prev_stall, prev_bit, prev_last;
        n    = VEC[v][3];
        mode = VEC[v][5];
        build_model(VEC[v][0], VEC[v][1], VEC[v][2], n, VEC[v][4]);
        idx = 0; oc = 0; mism = 0; last_bad = 0; stall_bad = 0; hold_bad = 0;
        got_last = 0; took = 0; restarted = 0; prev_stall = 0;
        prev_bit = 0; prev_last = 0;
        @(negedge clk);
        cfg_eini   = ERR_W'(VEC[v][0]);
        cfg_eminus = ERR_W'(VEC[v][1]);
        cfg_eplus  = ERR_W'(VEC[v][2]);
        cfg_len    = LEN_W'(n);
        cfg_start  = 1'b1;
        for (int cyc = 0; cyc < 5000 && !got_last; cyc++) begin
            @(negedge clk);
            cfg_start = 1'b0;
            // R8: a restart strobe with other settings mid-block
            if ((mode & 4) != 0 && !restarted && idx == n / 2) begin
                cfg_eini = 1; cfg_eminus = 9; cfg_eplus = 1; cfg_len = 3;
                cfg_start = 1'b1;
                restarted = 1'b1;
            end
            if (took) in_valid = 1'b0;
            took = 1'b0;
            if (!in_valid && idx < n && ((mode & 1) == 0 || (rnd() & 1) != 0)) begin
                in_valid = 1'b1;
                in_bit   = src[idx];
            end
            out_ready = ((mode & 2) == 0) ? 1'b1 : ((rnd() % 3) != 0);
            #1;
            if (prev_stall && !(out_valid && out_bit == prev_bit && out_last == prev_last))
                hold_bad++;
            prev_stall = out_valid && !out_ready;
            prev_bit   = out_bit;
            prev_last  = out_last;
            if (out_valid && out_ready) begin
                if (oc < MAXO && out_bit != exp_bits[oc]) mism++;
                if (out_last != (oc == exp_len - 1)) last_bad++;
                oc++;
                if (out_last) got_last = 1'b1;
            end
            if (in_valid && in_ready) begin
                if (idx >= n || oc != exp_first[idx]) stall_bad++;
                idx++;
                took = 1'b1;
            end
        end
        @(negedge clk);
        if (took) in_valid = 1'b0;
        cfg_start = 1'b0;
        #1;
        // R4: output count follows the recurrence
        check(oc == exp_len, "R4", $sformatf("vec %0d output count", v), oc, exp_len);
        // R3, R9: copies in order, count independent of bit value
        check(mism == 0, "R3 R9", $sformatf("vec %0d bit mismatches", v), mism, 0);
        // R6: last flag placement
        check(got_last && last_bad == 0, "R6", $sformatf("vec %0d last flag errors", v),
              last_bad + (got_last ? 0 : 1), 0);
        // R5: input taken only after all owed copies left
        check(stall_bad == 0, "R5", $sformatf("vec %0d early input accepts", v), stall_bad, 0);
        // R7: output held under backpressure
        check(hold_bad == 0, "R7", $sformatf("vec %0d hold violations", v), hold_bad, 0);
        // R6: idle after the last copy
        check(!out_valid && !in_ready, "R6", $sformatf("vec %0d idle after block", v),
              {out_valid, in_ready}, 0);
        if ((mode & 4) != 0)
            // R8: restart ignored, checked through the stream above
            check(restarted && oc == exp_len && mism == 0, "R8",
                  $sformatf("vec %0d restart ignored", v), oc, exp_len);
    endtask

    initial begin
        int bad;
        rst_n = 1'b0; cfg_start = 1'b0; cfg_eini = '0; cfg_eminus = '0;
        cfg_eplus = '0; cfg_len = '0; in_valid = 1'b0; in_bit = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(!out_valid && !in_ready && !out_last, "R1", "reset outputs",
              {out_valid, in_ready, out_last}, 0);
        // R1: no activity without start
        in_valid = 1'b1; out_ready = 1'b1;
        bad = 0;
        repeat (4) begin
            @(negedge clk); #1;
            if (in_ready || out_valid) bad++;
        end
        check(bad == 0, "R1", "active before start", bad, 0);
        in_valid = 1'b0;
        // R2: zero-length block stays idle
        @(negedge clk);
        cfg_len = '0; cfg_eini = 1; cfg_eminus = 1; cfg_eplus = 1; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0; in_valid = 1'b1;
        bad = 0;
        repeat (6) begin
            @(negedge clk); #1;
            if (in_ready || out_valid) bad++;
        end
        check(bad == 0, "R2", "zero-length block activity", bad, 0);
        in_valid = 1'b0;
        for (int v = 0; v < NV; v++) run_vec(v);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule